// File: doc/BRIEF.md
# Control-Register Handshake Master

This block sits between a simple host request port and the 16-bit internal control-register bus of a PHY. The host gives a 16-bit address, 16-bit write data, a direction flag and a one-cycle start pulse. The block then runs the PHY-side sequence without further help. Every access opens with an address-capture phase. A write then runs a data-capture phase followed by a write-strobe phase. A read instead runs a single read-strobe phase. On completion the block returns a done pulse, an error flag and, for reads, the captured data.

Each phase uses a full four-phase handshake. The block places a value on the shared data-in bus and holds it for a set number of setup cycles. It raises the phase's strobe and waits for acknowledge to go high. It then drops the strobe and waits for acknowledge to go low. Acknowledge is only looked at on a coarse poll tick. A phase that does not see the level it expects within a fixed number of polls abandons the whole access. When that happens the block lowers every strobe and reports done together with error.

Top module: `crbus_master`

## Requirements
- R1: Out of reset all four strobes are low, the data-in bus is zero, and done and error are low.
- R2: The value for a phase is on the data-in bus for at least SETUP_CYC cycles before that phase's strobe rises. The value stays unchanged while the strobe is high. For the address phase the value is the requested address.
- R3: A strobe stays high until acknowledge is sampled high and then falls. The next phase's setup starts only once acknowledge has been sampled low again.
- R4: No more than one of capture-address, capture-data, read and write is high in any cycle.
- R5: A write performs address capture, then data capture with the write data on data-in, then a write-strobe phase with the same data held. The read strobe is never raised.
- R6: A read drives zero on data-in during its read-strobe phase. The read data output takes the PHY data-out value present when acknowledge is sampled high in that phase. The access ends with done high and error low.
- R7: Acknowledge is sampled once every POLL_CYC cycles. A phase fails only if none of its first TIMEOUT_POLLS samples shows the expected level, and the last of those samples still counts. With the defaults, an acknowledge first high in the 32nd cycle of a strobe succeeds, and one first high in the 33rd cycle fails.
- R8: On a failed phase all strobes are low, and done and error are high together for exactly one cycle. This applies whether the missing level was acknowledge high or acknowledge low.
- R9: A start pulse that arrives while an access is in progress is ignored. It causes no extra address capture and does not change the running access.
- R10: Done is a one-cycle pulse, and error is low on every access that completes all its phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin an access |
| rw_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Data returned by the last read |
| done_o | output | 1 | One-cycle pulse at the end of an access |
| err_o | output | 1 | High with done when a phase timed out |
| phy_din_o | output | 16 | Shared address/data bus to the PHY |
| cap_addr_o | output | 1 | Capture-address strobe |
| cap_data_o | output | 1 | Capture-data strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| ack_i | input | 1 | Acknowledge from the PHY |
| dout_i | input | 16 | Read data from the PHY |

## Verification
Two events can fall in the same cycle: the poll that finally sees acknowledge, and the expiry of the phase timeout. The design resolves this so that the acknowledge wins. The bench provokes the collision with a responder whose acknowledge delay is set to land exactly on the last permitted poll, and again one cycle later. The first case must end with done, no error and correct read data. The second must end with error and all strobes low.

// File: rtl/crbus_pkg.sv
package crbus_pkg;
    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_DATA  = 2'd1,
        PH_WRITE = 2'd2,
        PH_READ  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_HOLD  = 2'd2,
        ST_DROP  = 2'd3
    } step_e;

    localparam int NUM_PHASES = 4;
endpackage

// File: rtl/crbus_poll_timer.sv
module crbus_poll_timer #(
    parameter int POLL_CYC      = 4,
    parameter int TIMEOUT_POLLS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o,
    output logic last_o
);
    localparam int PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam int NW = $clog2(TIMEOUT_POLLS + 1);

    typedef struct packed {
        logic [PW-1:0] pc;
        logic [NW-1:0] np;
    } tmr_t;

    tmr_t t_d, t_q;

    assign tick_o = run_i && (t_q.pc == PW'(POLL_CYC - 1));
    assign last_o = tick_o && (t_q.np == NW'(TIMEOUT_POLLS - 1));

    always_comb begin
        t_d = t_q;
        if (!run_i || restart_i) begin
            t_d.pc = '0;
            t_d.np = '0;
        end else if (tick_o) begin
            t_d.pc = '0;
            t_d.np = t_q.np + NW'(1);
        end else begin
            t_d.pc = t_q.pc + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/crbus_strobe_dec.sv
module crbus_strobe_dec
    import crbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  phase_e          phase_i,
    input  step_e           step_i,
    input  logic [DW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   din_o,
    output logic [NUM_PHASES-1:0] stb_o
);
    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_stb
        assign stb_o[p] = (step_i == ST_HOLD) && (phase_i == phase_e'(p));
    end

    always_comb begin
        din_o = '0;
        if (step_i != ST_IDLE) begin
            unique case (phase_i)
                PH_ADDR:           din_o = addr_i;
                PH_DATA, PH_WRITE: din_o = wdata_i;
                default:           din_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/crbus_master.sv
module crbus_master
    import crbus_pkg::*;
#(
    parameter int DW            = 16,
    parameter int SETUP_CYC     = 2,
    parameter int POLL_CYC      = 4,
    parameter int TIMEOUT_POLLS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          rw_i,
    input  logic [DW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          done_o,
    output logic          err_o,
    output logic [DW-1:0] phy_din_o,
    output logic          cap_addr_o,
    output logic          cap_data_o,
    output logic          rd_o,
    output logic          wr_o,
    input  logic          ack_i,
    input  logic [DW-1:0] dout_i
);
    localparam int SW = $clog2(SETUP_CYC + 1);

    typedef struct packed {
        step_e         step;
        phase_e        phase;
        logic          rw;
        logic [DW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic [SW-1:0] scnt;
        logic          done;
        logic          err;
    } seq_t;

    seq_t s_d, s_q;
    logic tick, last, restart, waiting, ack_ok;
    logic [NUM_PHASES-1:0] stb;

    assign waiting = (s_q.step == ST_HOLD) || (s_q.step == ST_DROP);
    assign ack_ok  = (s_q.step == ST_HOLD) ? ack_i : !ack_i;

    crbus_poll_timer #(
        .POLL_CYC      (POLL_CYC),
        .TIMEOUT_POLLS (TIMEOUT_POLLS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (waiting),
        .restart_i (restart),
        .tick_o    (tick),
        .last_o    (last)
    );

    crbus_strobe_dec #(.DW(DW)) u_dec (
        .phase_i (s_q.phase),
        .step_i  (s_q.step),
        .addr_i  (s_q.addr),
        .wdata_i (s_q.wdata),
        .din_o   (phy_din_o),
        .stb_o   (stb)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        restart  = 1'b0;
        unique case (s_q.step)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.step  = ST_SETUP;
                    s_d.phase = PH_ADDR;
                    s_d.rw    = rw_i;
                    s_d.addr  = addr_i;
                    s_d.wdata = wdata_i;
                    s_d.scnt  = '0;
                end
            end
            ST_SETUP: begin
                if (s_q.scnt == SW'(SETUP_CYC - 1)) s_d.step = ST_HOLD;
                else                                s_d.scnt = s_q.scnt + SW'(1);
            end
            default: begin
                if (tick && ack_ok) begin
                    if (s_q.step == ST_HOLD) begin
                        s_d.step = ST_DROP;
                        restart  = 1'b1;
                        if (s_q.phase == PH_READ) s_d.rdata = dout_i;
                    end else begin
                        s_d.scnt = '0;
                        unique case (s_q.phase)
                            PH_ADDR: begin
                                s_d.phase = s_q.rw ? PH_DATA : PH_READ;
                                s_d.step  = ST_SETUP;
                            end
                            PH_DATA: begin
                                s_d.phase = PH_WRITE;
                                s_d.step  = ST_SETUP;
                            end
                            default: begin
                                s_d.step = ST_IDLE;
                                s_d.done = 1'b1;
                            end
                        endcase
                    end
                end else if (last) begin
                    s_d.step = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.err  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.step  <= ST_IDLE;
            s_q.phase <= PH_ADDR;
        end else begin
            s_q <= s_d;
        end
    end

    assign cap_addr_o = stb[PH_ADDR];
    assign cap_data_o = stb[PH_DATA];
    assign wr_o       = stb[PH_WRITE];
    assign rd_o       = stb[PH_READ];
    assign rdata_o    = s_q.rdata;
    assign done_o     = s_q.done;
    assign err_o      = s_q.err;
endmodule

// File: rtl/crbus_master_chk.sv
module crbus_master_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done_o,
    input logic          err_o,
    input logic [DW-1:0] phy_din_o,
    input logic          cap_addr_o,
    input logic          cap_data_o,
    input logic          rd_o,
    input logic          wr_o,
    input logic          ack_i
);
    logic any_stb;
    assign any_stb = cap_addr_o | cap_data_o | rd_o | wr_o;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_addr_o, cap_data_o, rd_o, wr_o}));                    // R4
    AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_addr_o) |-> $stable(phy_din_o));                           // R2
    AST_DIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && $past(any_stb)) |-> $stable(phy_din_o));                 // R2
    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_stb) |-> ($past(ack_i) || err_o));                         // R3
    AST_READ_ZERO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |-> (phy_din_o == '0));                                         // R6
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && !any_stb));                                     // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                 // R10
endmodule

bind crbus_master crbus_master_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_o     (done_o),
    .err_o      (err_o),
    .phy_din_o  (phy_din_o),
    .cap_addr_o (cap_addr_o),
    .cap_data_o (cap_data_o),
    .rd_o       (rd_o),
    .wr_o       (wr_o),
    .ack_i      (ack_i)
);

// File: tb/crbus_master_bench.sv
`timescale 1ns/1ps
module crbus_master_bench;
    localparam int POLL  = 4;
    localparam int TPOLL = 8;
    localparam int LIMIT = POLL * TPOLL;   // latest acknowledge cycle that still succeeds

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, rw_i = 1'b0;
    logic [15:0] addr_i = '0, wdata_i = '0;
    logic [15:0] rdata_o, phy_din_o, dout_i;
    logic        done_o, err_o, cap_addr_o, cap_data_o, rd_o, wr_o;
    logic        ack_i = 1'b0;

    always #2.5 clk = ~clk;

    crbus_master #(.DW(16), .SETUP_CYC(2), .POLL_CYC(POLL), .TIMEOUT_POLLS(TPOLL)) u_crbus_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rw_i(rw_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o), .err_o(err_o),
        .phy_din_o(phy_din_o), .cap_addr_o(cap_addr_o), .cap_data_o(cap_data_o),
        .rd_o(rd_o), .wr_o(wr_o), .ack_i(ack_i), .dout_i(dout_i));

    int n_chk = 0, n_bad = 0;
    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // responder model of the PHY side
    logic [15:0] r_addr, r_data, wr_addr, wr_data, prev_din;
    int          wr_cnt, rd_cnt, acap_cnt, hi_cnt, stab, ack_dly;
    logic        have_addr, have_data, order_bad, setup_bad, prev_any, stuck;
    logic        any_stb;
    assign any_stb = cap_addr_o | cap_data_o | rd_o | wr_o;
    assign dout_i  = rd_o ? (r_addr ^ 16'h5AC3) : 16'hDEAD;

    initial begin ack_dly = 1; stuck = 1'b0; end

    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_addr <= '0; r_data <= '0; wr_addr <= '0; wr_data <= '0; prev_din <= '0;
            wr_cnt <= 0; rd_cnt <= 0; acap_cnt <= 0; hi_cnt <= 0; stab <= 0;
            have_addr <= 1'b0; have_data <= 1'b0; order_bad <= 1'b0; setup_bad <= 1'b0;
            prev_any <= 1'b0; ack_i <= 1'b0;
        end else begin
            stab     <= (phy_din_o == prev_din) ? stab + 1 : 0;
            prev_din <= phy_din_o;
            prev_any <= any_stb;
            if ($countones({cap_addr_o, cap_data_o, rd_o, wr_o}) > 1) order_bad <= 1'b1;
            if (any_stb && prev_any && phy_din_o != prev_din) order_bad <= 1'b1;
            if (any_stb && !prev_any) begin
                if (!(phy_din_o == prev_din && stab >= 1)) setup_bad <= 1'b1;
                if (cap_addr_o) begin
                    r_addr <= phy_din_o; have_addr <= 1'b1; have_data <= 1'b0;
                    acap_cnt <= acap_cnt + 1;
                end
                if (cap_data_o) begin
                    if (!have_addr) order_bad <= 1'b1;
                    r_data <= phy_din_o; have_data <= 1'b1;
                end
                if (wr_o) begin
                    if (!have_data || phy_din_o != r_data) order_bad <= 1'b1;
                    wr_addr <= r_addr; wr_data <= phy_din_o; wr_cnt <= wr_cnt + 1;
                    have_addr <= 1'b0;
                end
                if (rd_o) begin
                    if (!have_addr || phy_din_o != 16'h0) order_bad <= 1'b1;
                    rd_cnt <= rd_cnt + 1; have_addr <= 1'b0;
                end
            end
            if (any_stb) begin
                if (!ack_i) begin
                    hi_cnt <= hi_cnt + 1;
                    if (hi_cnt + 1 >= ack_dly) ack_i <= 1'b1;
                end
            end else begin
                hi_cnt <= 0;
                if (!stuck) ack_i <= 1'b0;
            end
        end
    end

    logic        res_err;
    logic [15:0] res_data;
    logic        res_stb;

    task automatic access(input logic rw, input logic [15:0] a, input logic [15:0] d, input int dly);
        ack_dly = dly;
        @(negedge clk);
        start_i = 1'b1; rw_i = rw; addr_i = a; wdata_i = d;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        res_err  = err_o;
        res_data = rdata_o;
        res_stb  = any_stb;
        @(negedge clk);
        chk(!done_o, "R10 done width", {31'd0, done_o}, 32'd0);
    endtask

    // {rw, addr, wdata, ack delay}
    localparam logic [40:0] VEC [8] = '{
        {1'b1, 16'h1234, 16'hBEEF, 8'd1},
        {1'b0, 16'h1234, 16'h0000, 8'd3},
        {1'b1, 16'hFFFF, 16'h0001, 8'd5},
        {1'b0, 16'h0000, 16'h0000, 8'd2},
        {1'b1, 16'h8001, 16'hA5A5, 8'd40},
        {1'b0, 16'h7E7E, 16'h0000, 8'd7},
        {1'b1, 16'h0102, 16'hFFFF, 8'd4},
        {1'b0, 16'hC0DE, 16'h0000, 8'd1}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int w0, a0, r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!any_stb && phy_din_o == 16'h0 && !done_o && !err_o, "R1 reset",
            {any_stb, done_o, err_o, phy_din_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            logic        vrw  = VEC[i][40];
            logic [15:0] va   = VEC[i][39:24];
            logic [15:0] vd   = VEC[i][23:8];
            int          vdly = int'(VEC[i][7:0]);
            logic        xerr = (vdly > LIMIT);
            w0 = wr_cnt; r0 = rd_cnt;
            access(vrw, va, vd, vdly);
            chk(res_err == xerr, "R8/R10 error flag", {31'd0, res_err}, {31'd0, xerr});
            if (xerr) begin
                chk(!res_stb, "R8 strobes low on abort", {31'd0, res_stb}, 32'd0);
            end else if (vrw) begin
                chk(wr_cnt == w0 + 1 && wr_addr == va && wr_data == vd, "R5 write delivered",
                    {wr_addr, wr_data}, {va, vd});
            end else begin
                chk(rd_cnt == r0 + 1 && res_data == (va ^ 16'h5AC3), "R6 read data",
                    {16'd0, res_data}, {16'd0, va ^ 16'h5AC3});
            end
        end

        // R7 boundary: acknowledge on the last permitted poll still succeeds
        access(1'b0, 16'h4321, 16'h0, LIMIT);
        chk(!res_err && res_data == (16'h4321 ^ 16'h5AC3), "R7 last poll accepted",
            {15'd0, res_err, res_data}, {16'd0, 16'h4321 ^ 16'h5AC3});
        // R7/R8: one cycle later fails
        r0 = rd_cnt;
        access(1'b0, 16'h4321, 16'h0, LIMIT + 1);
        chk(res_err && !res_stb && rd_cnt == r0, "R7 one cycle late aborts",
            {30'd0, res_err, res_stb}, 32'd2);

        // R8: acknowledge stuck high, release phase times out
        stuck = 1'b1;
        access(1'b1, 16'h0F0F, 16'h1111, 1);
        chk(res_err && !res_stb, "R8 stuck acknowledge aborts", {30'd0, res_err, res_stb}, 32'd2);
        stuck = 1'b0;
        repeat (4) @(negedge clk);

        // R9: start while busy is ignored
        a0 = acap_cnt; w0 = wr_cnt;
        ack_dly = 3;
        @(negedge clk);
        start_i = 1'b1; rw_i = 1'b1; addr_i = 16'h2468; wdata_i = 16'h1357;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        start_i = 1'b1; rw_i = 1'b0; addr_i = 16'h9999; wdata_i = 16'h0;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        chk(!err_o && acap_cnt == a0 + 1 && wr_cnt == w0 + 1 && wr_addr == 16'h2468 && wr_data == 16'h1357,
            "R9 busy start ignored", {wr_addr, wr_data}, {16'h2468, 16'h1357});
        repeat (POLL * 4) @(negedge clk);
        chk(acap_cnt == a0 + 1 && !any_stb, "R9 no second access", acap_cnt, a0 + 1);

        // R2/R3/R4/R5 protocol ordering seen by the responder
        chk(!setup_bad, "R2 setup before strobe", {31'd0, setup_bad}, 32'd0);
        chk(!order_bad, "R3/R4/R5 strobe ordering", {31'd0, order_bad}, 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule